// File: doc/BRIEF.md
# Timer Input Capture Channel

This block watches one external input pin and, when a qualifying edge event occurs, records the current count of one of two free-running 16-bit time bases. A software-visible mode field chooses which edges qualify: falling edges, rising edges, edges of either polarity, or every fourth or sixteenth rising edge. A single select bit picks which of the two timer inputs is sampled. The pin is brought into the clock domain through a two-flop synchronizer, and an edge is detected by comparing the synchronized level with its value one cycle earlier.

Recorded values wait in a four-entry first-in first-out store. The oldest value is always presented on the read data port, and a one-cycle read strobe removes it. Two status outputs report that the store holds data and that a capture was lost because the store was full. An interrupt request pulses for one cycle after a programmable number of stored captures, from one to four, have accumulated since the previous pulse.

Top module: `cap_channel`

## Requirements
- R1: After reset, buf_nempty, ovf and irq are all 0.
- R2: With cfg_mode = 3'b011, every rising edge of pin_in, and no falling edge, stores one timer value.
- R3: With cfg_mode = 3'b010, every falling edge of pin_in, and no rising edge, stores one timer value.
- R4: With cfg_mode = 3'b001, every edge of pin_in of either polarity stores one timer value.
- R5: With cfg_mode = 3'b100 a value is stored on every 4th rising edge, and with 3'b101 on every 16th, counting from the first rising edge after the channel leaves an off mode; falling edges are not counted.
- R6: The stored value is tbase_a when cfg_tsel is 0 and tbase_b when cfg_tsel is 1, as seen on the clock edge that stores it.
- R7: rd_data shows the oldest stored value; a cycle with rd_en high while buf_nempty is 1 removes it, so values leave in arrival order; rd_en while buf_nempty is 0 has no effect.
- R8: A capture that arrives while four values are stored (and no read occurs in that cycle) is discarded and sets ovf; ovf stays 1 until reads empty the store or the channel is switched off.
- R9: irq is a one-cycle pulse issued when the count of stored captures since the previous pulse reaches cfg_irq_thr + 1 (field value 0 to 3 meaning 1 to 4); the count then restarts from zero.
- R10: cfg_mode values 3'b000, 3'b110 and 3'b111 switch the channel off: no value is stored, and the store, ovf, the prescale count and the interrupt count are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 3 | Capture mode select |
| cfg_tsel | input | 1 | Time base select: 0 = tbase_a, 1 = tbase_b |
| cfg_irq_thr | input | 2 | Captures per interrupt, minus one |
| tbase_a | input | 16 | First time base count |
| tbase_b | input | 16 | Second time base count |
| pin_in | input | 1 | Asynchronous capture pin |
| rd_en | input | 1 | Read strobe, removes the oldest value |
| rd_data | output | 16 | Oldest stored value |
| buf_nempty | output | 1 | Store holds at least one value |
| ovf | output | 1 | A capture was lost to a full store |
| irq | output | 1 | Interrupt request pulse |

## Verification
The pin is toggled with random timer values held on both time bases, under each edge mode, both prescaled modes and the three off encodings, so that a capture on the wrong polarity, a miscounted prescaler or a wrong timer select shows up as a value in the store that the reference queue does not expect. Random reads interleaved with captures, including reads of an empty store, separate a correct arrival order from a reordered or double pop. A directed burst of five captures with a threshold of four tells apart the full-store discard, the overflow flag and its clearing on the last read, and the interrupt counter restarting after its pulse.

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_tsel,
  input  logic [1:0]    cfg_irq_thr,
  input  logic [TW-1:0] tbase_a,
  input  logic [TW-1:0] tbase_b,
  input  logic          pin_in,
  input  logic          rd_en,
  output logic [TW-1:0] rd_data,
  output logic          buf_nempty,
  output logic          ovf,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [2:0]    sync;
  logic          rise, fall, off, hit, pop, push, drop, full;
  logic [3:0]    pcnt;
  logic [1:0]    evc;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx;
  logic [TW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], pin_in};

  assign rise = sync[1] & ~sync[2];
  assign fall = ~sync[1] & sync[2];
  assign off  = (cfg_mode == 3'b000) || (cfg_mode[2:1] == 2'b11);

  always_comb begin
    case (cfg_mode)
      3'b001:  hit = rise | fall;
      3'b010:  hit = fall;
      3'b011:  hit = rise;
      3'b100:  hit = rise && (pcnt[1:0] == 2'd3);
      3'b101:  hit = rise && (pcnt == 4'd15);
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 pcnt <= '0;
    else if (off)                               pcnt <= '0;
    else if (rise && cfg_mode[2])               pcnt <= hit ? 4'd0 : pcnt + 4'd1;

  assign full = (cnt == CW'(DEPTH));
  assign pop  = rd_en && (cnt != '0) && !off;
  assign push = hit && (!full || pop);
  assign drop = hit && full && !pop;

  always_comb begin
    cnt_nx = cnt;
    if (push && !pop)      cnt_nx = cnt + CW'(1);
    else if (pop && !push) cnt_nx = cnt - CW'(1);
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= cfg_tsel ? tbase_b : tbase_a;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0; evc <= '0; irq <= 1'b0;
    end else if (off) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0; evc <= '0; irq <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt <= cnt_nx;
      if (drop)              ovf <= 1'b1;
      else if (cnt_nx == '0) ovf <= 1'b0;
      irq <= push && (evc == cfg_irq_thr);
      if (push) evc <= (evc == cfg_irq_thr) ? 2'd0 : evc + 2'd1;
    end

  assign rd_data    = mem[rp];
  assign buf_nempty = (cnt != '0);
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cfg_mode,
  input logic          rd_en,
  input logic [TW-1:0] rd_data,
  input logic          buf_nempty,
  input logic          ovf,
  input logic          irq
);
  logic off;
  assign off = (cfg_mode == 3'b000) || (cfg_mode[2:1] == 2'b11);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!buf_nempty && !ovf && !irq)); // R10
  AST_OVF_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> buf_nempty); // R8
  AST_OVF_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(buf_nempty)); // R8
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_nempty); // R9
  AST_EMPTY_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_nempty) |-> ($past(rd_en) || $past(off))); // R7
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_nempty && !rd_en && !off) |=> $stable(rd_data)); // R7
endmodule

bind cap_channel cap_channel_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .rd_en(rd_en),
  .rd_data(rd_data), .buf_nempty(buf_nempty), .ovf(ovf), .irq(irq)
);

// File: tb/cap_channel_tb.sv
module cap_channel_tb;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  cfg_mode = 0;
  logic        cfg_tsel = 0;
  logic [1:0]  cfg_irq_thr = 0;
  logic [15:0] tbase_a = 0, tbase_b = 0;
  logic        pin_in = 0, rd_en = 0;
  logic [15:0] rd_data;
  logic        buf_nempty, ovf, irq;

  int checks = 0, fails = 0, irq_seen = 0, irq_exp = 0;
  int q[$];
  bit m_ovf = 0;
  int m_pc = 0, m_ev = 0;

  always #5 clk = ~clk;

  cap_channel u_dut (.*);

  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mode_off(logic [2:0] m);
    return m == 3'b000 || m[2:1] == 2'b11;
  endfunction

  function automatic string mtag(logic [2:0] m);
    case (m)
      3'b001: return "R4";
      3'b010: return "R3";
      3'b011: return "R2";
      3'b100, 3'b101: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic bit model_hit(logic [2:0] m, bit rising);
    bit h = 0;
    case (m)
      3'b001: h = 1;
      3'b010: h = !rising;
      3'b011: h = rising;
      3'b100, 3'b101: if (rising) begin
        int lim = (m == 3'b100) ? 3 : 15;
        h = (m_pc == lim);
        m_pc = h ? 0 : m_pc + 1;
      end
      default: h = 0;
    endcase
    return h;
  endfunction

  task automatic status(string tag);
    check(buf_nempty == (q.size() != 0), {tag, " nempty"}, buf_nempty, q.size() != 0);
    check(ovf == m_ovf, {"R8 ovf ", tag}, ovf, m_ovf);
    check(irq_seen == irq_exp, {"R9 irq count ", tag}, irq_seen, irq_exp);
    check(irq == 0, "R9 pulse", irq, 0);
  endtask

  task automatic set_mode(logic [2:0] m, logic [1:0] thr, logic ts);
    @(negedge clk);
    cfg_mode = 3'b000;
    repeat (2) @(negedge clk);
    q.delete(); m_ovf = 0; m_pc = 0; m_ev = 0;
    status("R10 off");
    cfg_irq_thr = thr; cfg_tsel = ts; cfg_mode = m;
    @(negedge clk);
  endtask

  task automatic toggle();
    int v;
    tbase_a = 16'($urandom); tbase_b = 16'($urandom);
    v = cfg_tsel ? int'(tbase_b) : int'(tbase_a);
    pin_in = ~pin_in;
    if (model_hit(cfg_mode, pin_in)) begin
      if (q.size() < 4) begin
        q.push_back(v);
        if (m_ev == int'(cfg_irq_thr)) begin m_ev = 0; irq_exp++; end
        else m_ev++;
      end else m_ovf = 1;
    end
    repeat (5) @(negedge clk);
    status(mtag(cfg_mode));
  endtask

  task automatic read_one();
    if (q.size() != 0) begin
      check(rd_data == 16'(q[0]), "R7 R6 order/value", rd_data, q[0]);
      void'(q.pop_front());
      if (q.size() == 0) m_ovf = 0;
    end
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
    status("R7 read");
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    check(buf_nempty == 0 && ovf == 0 && irq == 0, "R1 reset", {buf_nempty, ovf, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    check(buf_nempty == 0 && ovf == 0 && irq == 0, "R1 after release", {buf_nempty, ovf, irq}, 0);

    // directed: empty read, overflow, threshold of four
    set_mode(3'b011, 2'd3, 1'b1);
    read_one();
    for (int i = 0; i < 10; i++) toggle();
    check(ovf == 1, "R8 set after fifth capture", ovf, 1);
    check(irq_exp == 1, "R9 one pulse for four", irq_exp, 1);
    for (int i = 0; i < 4; i++) read_one();
    check(ovf == 0, "R8 cleared by emptying", ovf, 0);
    read_one();

    // directed: reserved off encoding blocks capture
    set_mode(3'b110, 2'd0, 1'b0);
    for (int i = 0; i < 4; i++) toggle();
    check(buf_nempty == 0, "R10 mode 110 no capture", buf_nempty, 0);

    // directed: every 16th rising edge, time base A
    set_mode(3'b101, 2'd0, 1'b0);
    for (int i = 0; i < 32; i++) toggle();
    check(q.size() == 1, "R5 one capture per 16 rising", q.size(), 1);
    read_one();

    // random
    for (int blk = 0; blk < 30; blk++) begin
      set_mode(3'($urandom_range(0, 7)), 2'($urandom), 1'($urandom));
      for (int s = 0; s < 24; s++) begin
        if ($urandom_range(0, 2) == 0) read_one();
        else toggle();
      end
      while (q.size() != 0) read_one();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule